// File: doc/BRIEF.md
# Multiprocessor Receive Address Filter

This block sits behind a UART receiver working with 9-bit characters, where the ninth bit tells address characters apart from data characters. Each completed character arrives with a one-cycle strobe. The block decides whether that character should raise a receive interrupt request and be handed on. Accepted characters leave on an output port one cycle later, together with a one-cycle request pulse.

The decision depends on three things: an enable bit, a 2-bit filter mode and an 8-bit compare address. With the enable bit clear, nothing is filtered. With it set, the mode selects one of three policies:
- pass everything;
- pass only address characters;
- pass a matching address, and after it all data until the next address that does not match.

The block keeps a sticky "selected" flag for the third policy and shows it on an output.

The control fields are written through a banked write port. Only bank 000 holds them. The compare address has its own write port.

Top module: `mpu_rx_filter`

## Requirements
- R1: After synchronous reset, out_valid and addressed are 0, the mode is 00 and filtering is off, so the first character after reset is passed on.
- R2: With the enable bit (cfg_wdata[2]) clear, every received character is passed on whatever the mode field holds, and addressed stays 0.
- R3: With filtering on and mode 00 (cfg_wdata[1:0]), both address characters (rx_is_addr=1) and data characters are passed on.
- R4: With filtering on and mode 01, address characters are passed on and data characters produce no output.
- R5: With filtering on and mode 10, an address character equal to the compare address is passed on and sets addressed to 1.
- R6: In mode 10, data characters are passed on while addressed is 1 and dropped while it is 0.
- R7: In mode 10, an address character that differs from the compare address is dropped and clears addressed.
- R8: Mode 11 behaves exactly as mode 10.
- R9: A control write with cfg_bank equal to 000 clears addressed. A control write to any other bank changes neither the mode nor addressed.
- R10: A compare address write applies from the next character on. A character received in the same cycle as the write is judged against the old value.
- R11: An accepted character appears on out_data and out_is_addr with out_valid high for exactly one cycle, on the clock edge that follows its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_bank | input | 3 | Bank select; bank 000 holds the filter controls |
| cfg_wdata | input | 3 | [1:0] filter mode, [2] filtering enable |
| cmp_we | input | 1 | Compare address write strobe |
| cmp_wdata | input | 8 | New compare address |
| rx_valid | input | 1 | One-cycle strobe for a completed character |
| rx_data | input | 8 | Received character data |
| rx_is_addr | input | 1 | Ninth bit: 1 for an address character |
| out_valid | output | 1 | Interrupt request pulse for an accepted character |
| out_data | output | 8 | Accepted character data |
| out_is_addr | output | 1 | Address flag of the accepted character |
| addressed | output | 1 | Sticky selected state used by modes 10 and 11 |

## Verification
The only internal state that matters is the sticky selected flag and the stored controls. A wrong selected flag shows up on the `addressed` output at the next edge. At the ports, it shows up when the next data character is passed on or dropped, which is one cycle after that character's strobe. A wrong mode or compare value shows up as an extra or missing request pulse on the very next character. The scoreboard therefore follows each character individually, checks that the queue drains after each scenario, and reads `addressed` at the points where it must change.

// File: rtl/mpf_pkg.sv
package mpf_pkg;

    localparam int DATA_W   = 8;
    localparam int BANK_W   = 3;
    localparam int MODE_W   = 2;
    localparam int CTRL_W   = MODE_W + 1;
    localparam int EN_BIT   = MODE_W;
    localparam logic [BANK_W-1:0] CTRL_BANK = '0;

    typedef enum logic [MODE_W-1:0] {
        FM_ALL       = 2'b00,
        FM_ADDR_ONLY = 2'b01,
        FM_MATCH     = 2'b10,
        FM_MATCH_ALT = 2'b11
    } filt_mode_e;

    typedef struct packed {
        logic       en;
        filt_mode_e mode;
    } ctrl_t;

    typedef struct packed {
        logic              is_addr;
        logic [DATA_W-1:0] data;
    } rx_char_t;

    function automatic logic uses_match(input ctrl_t c);
        return c.en && c.mode[MODE_W-1];
    endfunction

    function automatic logic should_pass(input ctrl_t c, input logic is_addr,
                                         input logic hit, input logic sel);
        logic p;
        if (!c.en) begin
            p = 1'b1;
        end else begin
            case (c.mode)
                FM_ALL:       p = 1'b1;
                FM_ADDR_ONLY: p = is_addr;
                default:      p = is_addr ? hit : sel;
            endcase
        end
        return p;
    endfunction

endpackage

// File: rtl/mpf_ctrl_regs.sv
module mpf_ctrl_regs
    import mpf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [BANK_W-1:0] cfg_bank,
    input  logic [CTRL_W-1:0] cfg_wdata,
    input  logic              cmp_we,
    input  logic [DATA_W-1:0] cmp_wdata,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] cmp_addr,
    output logic              cfg_touch
);

    assign cfg_touch = cfg_we && (cfg_bank == CTRL_BANK);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '{en: 1'b0, mode: FM_ALL};
            cmp_addr <= '0;
        end else begin
            if (cfg_touch) begin
                ctrl.en   <= cfg_wdata[EN_BIT];
                ctrl.mode <= filt_mode_e'(cfg_wdata[MODE_W-1:0]);
            end
            if (cmp_we) begin
                cmp_addr <= cmp_wdata;
            end
        end
    end

    // R9: a write to another bank leaves the controls unchanged
    a_r9_other_bank_ignored: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_bank != CTRL_BANK) |=> $stable(ctrl));

endmodule

// File: rtl/mpf_addr_track.sv
module mpf_addr_track
    import mpf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rx_valid,
    input  logic rx_is_addr,
    input  logic hit,
    input  logic filt_on,
    input  logic cfg_touch,
    output logic addressed
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addressed <= 1'b0;
        end else if (cfg_touch) begin
            addressed <= 1'b0;
        end else if (rx_valid && filt_on && rx_is_addr) begin
            addressed <= hit;
        end
    end

    // R9: a control bank write clears the selected state
    a_r9_cfg_clears: assert property (@(posedge clk) disable iff (rst)
        cfg_touch |=> !addressed);

    // R5: a matching address sets the selected state
    a_r5_match_sets: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && filt_on && rx_is_addr && hit && !cfg_touch) |=> addressed);

    // R7: a mismatching address clears the selected state
    a_r7_mismatch_clears: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && filt_on && rx_is_addr && !hit) |=> !addressed);

endmodule

// File: rtl/mpf_accept.sv
module mpf_accept
    import mpf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic [DATA_W-1:0] cmp_addr,
    input  logic              rx_valid,
    input  rx_char_t          rx_char,
    input  logic              addressed,
    output logic              hit,
    output logic              out_valid,
    output rx_char_t          out_char
);

    logic pass;

    assign hit  = (rx_char.data == cmp_addr);
    assign pass = should_pass(ctrl, rx_char.is_addr, hit, addressed);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_char  <= '0;
        end else begin
            out_valid <= rx_valid && pass;
            if (rx_valid && pass) begin
                out_char <= rx_char;
            end
        end
    end

    // R11: a request pulse only ever follows a strobe and carries its character
    a_r11_follows_strobe: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(rx_valid) && out_char == $past(rx_char)));

    // R2: with filtering off every strobe yields a request
    a_r2_plain_pass: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !ctrl.en) |=> out_valid);

    // R4: address-only mode drops data characters
    a_r4_data_dropped: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && ctrl.en && ctrl.mode == FM_ADDR_ONLY && !rx_char.is_addr)
        |=> !out_valid);

    // R6: data is dropped while not selected
    a_r6_unselected_drop: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && uses_match(ctrl) && !rx_char.is_addr && !addressed)
        |=> !out_valid);

endmodule

// File: rtl/mpu_rx_filter.sv
module mpu_rx_filter
    import mpf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [BANK_W-1:0] cfg_bank,
    input  logic [CTRL_W-1:0] cfg_wdata,
    input  logic              cmp_we,
    input  logic [DATA_W-1:0] cmp_wdata,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_is_addr,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_is_addr,
    output logic              addressed
);

    ctrl_t             ctrl;
    logic [DATA_W-1:0] cmp_addr;
    logic              cfg_touch;
    logic              hit;
    rx_char_t          rx_char;
    rx_char_t          out_char;

    assign rx_char = '{is_addr: rx_is_addr, data: rx_data};

    mpf_ctrl_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_bank  (cfg_bank),
        .cfg_wdata (cfg_wdata),
        .cmp_we    (cmp_we),
        .cmp_wdata (cmp_wdata),
        .ctrl      (ctrl),
        .cmp_addr  (cmp_addr),
        .cfg_touch (cfg_touch)
    );

    mpf_accept u_accept (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .cmp_addr  (cmp_addr),
        .rx_valid  (rx_valid),
        .rx_char   (rx_char),
        .addressed (addressed),
        .hit       (hit),
        .out_valid (out_valid),
        .out_char  (out_char)
    );

    mpf_addr_track u_track (
        .clk        (clk),
        .rst        (rst),
        .rx_valid   (rx_valid),
        .rx_is_addr (rx_is_addr),
        .hit        (hit),
        .filt_on    (uses_match(ctrl)),
        .cfg_touch  (cfg_touch),
        .addressed  (addressed)
    );

    assign out_data    = out_char.data;
    assign out_is_addr = out_char.is_addr;

    // R1: nothing is requested and nothing is selected in the cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !addressed));

endmodule

// File: tb/mpu_rx_filter_test.sv
module mpu_rx_filter_test;

    typedef struct {
        logic       a;
        logic [7:0] d;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_bank = '0;
    logic [2:0] cfg_wdata = '0;
    logic       cmp_we = 1'b0;
    logic [7:0] cmp_wdata = '0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_is_addr = 1'b0;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_is_addr;
    logic       addressed;

    int   total = 0;
    int   bad = 0;
    bit   done = 0;
    exp_t q[$];

    always #4 clk = ~clk;

    mpu_rx_filter uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
        .cfg_wdata(cfg_wdata), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_is_addr(rx_is_addr),
        .out_valid(out_valid), .out_data(out_data), .out_is_addr(out_is_addr),
        .addressed(addressed)
    );

    // monitor: compare each request pulse with the oldest expected character
    always @(negedge clk) begin : mon
        exp_t e;
        if (!rst && out_valid) begin
            total++;
            if (q.size() == 0) begin
                bad++;
                $display("FAIL unexpected request: got a=%0b d=%02h, expected none",
                         out_is_addr, out_data);
            end else begin
                e = q.pop_front();
                if (out_is_addr !== e.a || out_data !== e.d) begin
                    bad++;
                    $display("FAIL %s: got a=%0b d=%02h, expected a=%0b d=%02h",
                             e.tag, out_is_addr, out_data, e.a, e.d);
                end
            end
        end
    end

    task automatic send(input logic a, input logic [7:0] d, input bit pass, input string tag);
        @(negedge clk);
        rx_valid = 1'b1; rx_is_addr = a; rx_data = d;
        if (pass) q.push_back('{a: a, d: d, tag: tag});
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic set_ctrl(input logic [2:0] bank, input logic en, input logic [1:0] mode);
        @(negedge clk);
        cfg_we = 1'b1; cfg_bank = bank; cfg_wdata = {en, mode};
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_cmp(input logic [7:0] v);
        @(negedge clk);
        cmp_we = 1'b1; cmp_wdata = v;
        @(negedge clk);
        cmp_we = 1'b0;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got %0d, expected %0d", tag, act, exp);
        end
    endtask

    // let the queue drain and confirm the pulse has ended (R11)
    task automatic drain(input string tag);
        @(negedge clk);
        @(negedge clk);
        check(q.size() == 0, {tag, " missing request"}, q.size(), 0);
        check(out_valid == 1'b0, "R11 pulse width", out_valid, 0);
    endtask

    task automatic chk_sel(input logic exp, input string tag);
        @(negedge clk);
        check(addressed === exp, tag, addressed, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(out_valid === 1'b0, "R1 out_valid after reset", out_valid, 0);
        check(addressed === 1'b0, "R1 addressed after reset", addressed, 0);
        send(1'b0, 8'h11, 1, "R1 default pass");
        drain("R1");

        // R2: enable clear, mode field set
        set_ctrl(3'b000, 1'b0, 2'b01);
        send(1'b0, 8'h21, 1, "R2 data");
        send(1'b1, 8'h22, 1, "R2 addr");
        set_ctrl(3'b000, 1'b0, 2'b10);
        send(1'b1, 8'h00, 1, "R2 addr mode10");
        send(1'b0, 8'h23, 1, "R2 data mode10");
        drain("R2");
        chk_sel(1'b0, "R2 addressed stays 0");

        // R3
        set_ctrl(3'b000, 1'b1, 2'b00);
        send(1'b0, 8'h31, 1, "R3 data");
        send(1'b1, 8'h32, 1, "R3 addr");
        drain("R3");

        // R4
        set_ctrl(3'b000, 1'b1, 2'b01);
        send(1'b0, 8'h41, 0, "R4 data");
        send(1'b1, 8'h42, 1, "R4 addr");
        send(1'b0, 8'h43, 0, "R4 data");
        drain("R4");

        // R5 / R6 / R7 in mode 10
        set_cmp(8'h5A);
        set_ctrl(3'b000, 1'b1, 2'b10);
        send(1'b0, 8'h51, 0, "R6 data unselected");
        send(1'b1, 8'h5A, 1, "R5 match");
        chk_sel(1'b1, "R5 addressed set");
        send(1'b0, 8'h61, 1, "R6 data selected");
        send(1'b0, 8'h62, 1, "R6 data selected");
        send(1'b1, 8'h33, 0, "R7 mismatch");
        chk_sel(1'b0, "R7 addressed cleared");
        send(1'b0, 8'h63, 0, "R7 data after mismatch");
        drain("R7");

        // R8: mode 11
        set_ctrl(3'b000, 1'b1, 2'b11);
        send(1'b0, 8'h81, 0, "R8 data unselected");
        send(1'b1, 8'h5A, 1, "R8 match");
        send(1'b0, 8'h82, 1, "R8 data selected");
        send(1'b1, 8'h5B, 0, "R8 mismatch");
        send(1'b0, 8'h83, 0, "R8 data dropped");
        drain("R8");

        // R9
        set_ctrl(3'b000, 1'b1, 2'b10);
        send(1'b1, 8'h5A, 1, "R9 select");
        set_ctrl(3'b001, 1'b0, 2'b00);
        chk_sel(1'b1, "R9 other bank keeps addressed");
        send(1'b0, 8'h91, 1, "R9 mode kept");
        set_ctrl(3'b000, 1'b1, 2'b10);
        chk_sel(1'b0, "R9 bank0 clears addressed");
        send(1'b0, 8'h92, 0, "R9 data after clear");
        drain("R9");

        // R10: compare write and character in the same cycle
        @(negedge clk);
        cmp_we = 1'b1; cmp_wdata = 8'h77;
        rx_valid = 1'b1; rx_is_addr = 1'b1; rx_data = 8'h5A;
        q.push_back('{a: 1'b1, d: 8'h5A, tag: "R10 old value"});
        @(negedge clk);
        cmp_we = 1'b0; rx_valid = 1'b0;
        send(1'b1, 8'h5A, 0, "R10 stale value");
        send(1'b1, 8'h77, 1, "R10 new value");
        drain("R10");

        // R11: back-to-back characters
        set_ctrl(3'b000, 1'b1, 2'b00);
        @(negedge clk);
        rx_valid = 1'b1; rx_is_addr = 1'b0; rx_data = 8'hB1;
        q.push_back('{a: 1'b0, d: 8'hB1, tag: "R11 first"});
        @(negedge clk);
        rx_is_addr = 1'b1; rx_data = 8'hB2;
        q.push_back('{a: 1'b1, d: 8'hB2, tag: "R11 second"});
        @(negedge clk);
        rx_valid = 1'b0;
        drain("R11");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule